// File: doc/BRIEF.md
# Two-Channel Sample Ready and Conversion Sync Controller

This block sets the update timing of two sample channels, an angular rate channel and a temperature channel. The two channels take turns on a fixed cadence. An internal divider produces one conversion slot every `TICK_PERIOD` clock cycles, and the slots go alternately to the rate channel and then the temperature channel. Each channel keeps a data register and a flag that marks unread data. An active-low ready line tells the host when data is waiting. A mode input chooses whether one fresh channel is enough to pull the line low, or whether every enabled channel must hold fresh data first. A completed read of either data register releases the line.

Conversions can also be tied to an external timing pulse. When synchronization is enabled and the sync pin is low, the divider and the channel order are held at their start point. The first slot after the sync pin rises goes to the rate channel, a whole period later. A stub generator supplies the sample values: each slot's value is one more than the value of the previous slot. This makes lost and delivered samples easy to tell apart.

Top module: `drdy_sync_ctrl`

## Requirements
- R1: Slots come every `TICK_PERIOD` cycles. They alternate between the rate and temperature channels, starting with the rate channel. The two update pulses never occur in the same cycle, and a temperature update follows a rate update by exactly `TICK_PERIOD` cycles.
- R2: When `all_mode_i` is 0, `rdy_no` goes low in the cycle of an update that leaves at least one enabled channel holding unread data.
- R3: When `all_mode_i` is 1, `rdy_no` goes low only on an update after which every enabled channel holds unread data. An update that leaves an enabled channel without unread data keeps `rdy_no` high.
- R4: A one-cycle read-done pulse on either channel drives `rdy_no` high from the next cycle. The exception is an update in that same cycle that meets the active policy: the update takes precedence and `rdy_no` stays low.
- R5: A channel with its enable input at 0 never updates. Its slot still comes and goes in the alternation, and its data output is unchanged.
- R6: If a channel's read-busy input is 1 during its slot, the new sample is discarded. There is no update pulse, and the data register keeps its old value.
- R7: While `sync_en_i` is 1 and `sync_i` is 0, no update occurs on either channel.
- R8: After `sync_i` rises with synchronization enabled, the first update goes to the rate channel. Its pulse appears `TICK_PERIOD` cycles after the first cycle with `sync_i` high.
- R9: The sample offered in each slot is one more than the sample of the previous slot, whether that earlier sample was delivered or discarded. The first slot after reset offers 0.
- R10: In reset, `rdy_no` is 1, both update pulses are 0, both data registers are 0, and no channel holds unread data.
- R11: An update pulse is high for exactly one cycle, and that is the cycle in which the channel's data output first shows the new sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| all_mode_i | input | 1 | 1: ready only when all enabled channels are unread; 0: any one |
| sync_en_i | input | 1 | Enable conversion hold by the sync pin |
| sync_i | input | 1 | Sync pin, synchronous to clk_i; low holds conversions when enabled |
| rate_en_i | input | 1 | Rate channel enable |
| temp_en_i | input | 1 | Temperature channel enable |
| rate_rd_busy_i | input | 1 | Read of the rate data register in progress |
| rate_rd_done_i | input | 1 | One-cycle pulse: rate data register read completed |
| temp_rd_busy_i | input | 1 | Read of the temperature data register in progress |
| temp_rd_done_i | input | 1 | One-cycle pulse: temperature data register read completed |
| rate_upd_o | output | 1 | Rate channel update pulse |
| temp_upd_o | output | 1 | Temperature channel update pulse |
| rate_data_o | output | DATA_W | Rate data register |
| temp_data_o | output | DATA_W | Temperature data register |
| rdy_no | output | 1 | Data ready, active low |

## Verification
A read-done pulse on one channel can arrive in the same cycle as the other channel's update. Both act on the ready line, so the precedence rule decides the result. The bench provokes this by counting `TICK_PERIOD - 1` cycles from an observed rate update and pulsing the rate read-done so that it meets the temperature slot edge. It then requires the temperature update pulse and a low ready line together in the following cycle. A second overlap is a read-busy window covering a channel's own slot. That case is judged by the missing pulse, the unchanged register, and the sample value of the next delivered update, which must jump by four.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  localparam int unsigned NCH = 2;
  typedef enum logic {CH_RATE = 1'b0, CH_TEMP = 1'b1} chan_e;
endpackage

// File: rtl/drdy_tick_gen.sv
module drdy_tick_gen #(
  parameter int unsigned TICK_PERIOD = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = !hold_i && wrap;

  // hold parks the divider at zero so a release restarts a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (TICK_PERIOD > 1) begin : g_gap
      p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/drdy_chan_seq.sv
module drdy_chan_seq
  import drdy_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           tick_i,
  output logic [NCH-1:0] req_o
);
  chan_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= CH_RATE;
    else if (hold_i)  sel_q <= CH_RATE;
    else if (tick_i)  sel_q <= (sel_q == CH_RATE) ? CH_TEMP : CH_RATE;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_req
    assign req_o[c] = tick_i && (int'(sel_q) == c);
  end

  p_resume_rate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (sel_q == CH_RATE));
  p_one_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));
endmodule

// File: rtl/drdy_sample_stub.sv
module drdy_sample_stub #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [DATA_W-1:0] sample_o
);
  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign sample_o = cnt_q;
endmodule

// File: rtl/drdy_chan_slot.sv
module drdy_chan_slot #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              en_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              upd_ev_o,
  output logic              unread_n_o,
  output logic              upd_o,
  output logic [DATA_W-1:0] data_o
);
  logic              unread_q;
  logic              upd_q;
  logic [DATA_W-1:0] data_q;

  // a read in flight keeps the old word; the slot's sample is dropped
  assign upd_ev_o   = req_i && en_i && !busy_i;
  assign unread_n_o = upd_ev_o ? 1'b1 : (done_i ? 1'b0 : unread_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      unread_q <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      unread_q <= unread_n_o;
      upd_q    <= upd_ev_o;
      if (upd_ev_o) data_q <= sample_i;
    end
  end

  assign upd_o  = upd_q;
  assign data_o = data_q;

  p_busy_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_i) |=> ($stable(data_q) && !upd_o));
  p_dis_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !upd_o);
  p_upd_fresh_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> unread_q);
  p_upd_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !req_i) |=> !upd_o);
endmodule

// File: rtl/drdy_rdy_policy.sv
module drdy_rdy_policy
  import drdy_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           all_mode_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] upd_ev_i,
  input  logic [NCH-1:0] rd_done_i,
  input  logic [NCH-1:0] unread_n_i,
  output logic           rdy_no
);
  logic low_q;
  logic cond;

  always_comb begin
    if (all_mode_i) cond = (&(unread_n_i | ~en_i)) && (|en_i);
    else            cond = |(unread_n_i & en_i);
  end

  // update that meets the policy wins over a read finishing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      low_q <= 1'b0;
    else if ((|upd_ev_i) && cond)     low_q <= 1'b1;
    else if (|rd_done_i)              low_q <= 1'b0;
  end

  assign rdy_no = !low_q;

  p_read_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rd_done_i) && !(|upd_ev_i)) |=> rdy_no);
  p_fall_on_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_no && !(|upd_ev_i)) |=> rdy_no);
endmodule

// File: rtl/drdy_sync_ctrl.sv
module drdy_sync_ctrl
  import drdy_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned TICK_PERIOD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              all_mode_i,
  input  logic              sync_en_i,
  input  logic              sync_i,
  input  logic              rate_en_i,
  input  logic              temp_en_i,
  input  logic              rate_rd_busy_i,
  input  logic              rate_rd_done_i,
  input  logic              temp_rd_busy_i,
  input  logic              temp_rd_done_i,
  output logic              rate_upd_o,
  output logic              temp_upd_o,
  output logic [DATA_W-1:0] rate_data_o,
  output logic [DATA_W-1:0] temp_data_o,
  output logic              rdy_no
);
  logic              hold;
  logic              tick;
  logic [NCH-1:0]    req;
  logic [NCH-1:0]    en;
  logic [NCH-1:0]    busy;
  logic [NCH-1:0]    done;
  logic [NCH-1:0]    upd_ev;
  logic [NCH-1:0]    unread_n;
  logic [NCH-1:0]    upd;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] data [NCH];

  assign hold = sync_en_i && !sync_i;

  assign en   = {temp_en_i, rate_en_i};
  assign busy = {temp_rd_busy_i, rate_rd_busy_i};
  assign done = {temp_rd_done_i, rate_rd_done_i};

  drdy_tick_gen #(.TICK_PERIOD(TICK_PERIOD)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .tick_o(tick)
  );

  drdy_chan_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .tick_i(tick),
    .req_o (req)
  );

  drdy_sample_stub #(.DATA_W(DATA_W)) u_stub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .sample_o(sample)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    drdy_chan_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req[c]),
      .en_i      (en[c]),
      .busy_i    (busy[c]),
      .done_i    (done[c]),
      .sample_i  (sample),
      .upd_ev_o  (upd_ev[c]),
      .unread_n_o(unread_n[c]),
      .upd_o     (upd[c]),
      .data_o    (data[c])
    );
  end

  drdy_rdy_policy u_rdy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .all_mode_i(all_mode_i),
    .en_i      (en),
    .upd_ev_i  (upd_ev),
    .rd_done_i (done),
    .unread_n_i(unread_n),
    .rdy_no    (rdy_no)
  );

  assign rate_upd_o  = upd[CH_RATE];
  assign temp_upd_o  = upd[CH_TEMP];
  assign rate_data_o = data[CH_RATE];
  assign temp_data_o = data[CH_TEMP];

  p_one_upd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rate_upd_o && temp_upd_o));
  p_sync_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && !sync_i) |=> (!rate_upd_o && !temp_upd_o));
  p_sync_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && !sync_i) |=> ($stable(rate_data_o) && $stable(temp_data_o)));
endmodule

// File: tb/drdy_sync_ctrl_tb_top.sv
module drdy_sync_ctrl_tb_top;
  localparam int unsigned DW  = 24;
  localparam int unsigned PER = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic all_mode = 1'b0, sync_en = 1'b0, sync_p = 1'b0;
  logic rate_en = 1'b1, temp_en = 1'b1;
  logic rate_busy = 1'b0, rate_done = 1'b0, temp_busy = 1'b0, temp_done = 1'b0;
  logic rate_upd, temp_upd, rdy_n;
  logic [DW-1:0] rate_data, temp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  drdy_sync_ctrl #(.DATA_W(DW), .TICK_PERIOD(PER)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .all_mode_i(all_mode), .sync_en_i(sync_en),
    .sync_i(sync_p), .rate_en_i(rate_en), .temp_en_i(temp_en),
    .rate_rd_busy_i(rate_busy), .rate_rd_done_i(rate_done),
    .temp_rd_busy_i(temp_busy), .temp_rd_done_i(temp_done),
    .rate_upd_o(rate_upd), .temp_upd_o(temp_upd),
    .rate_data_o(rate_data), .temp_data_o(temp_data), .rdy_no(rdy_n)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // wait for an update pulse on one channel; count pulses on the other meanwhile
  task automatic wait_upd(input bit temp_ch, output int other);
    int n = 0;
    other = 0;
    while (1) begin
      step();
      n++;
      if (temp_ch ? temp_upd : rate_upd) break;
      if (temp_ch ? rate_upd : temp_upd) other++;
      if (n > 4 * PER) begin
        chk(1'b0, "timeout", n, 4 * PER);
        break;
      end
    end
  endtask

  task automatic pulse_done(input bit temp_ch);
    if (temp_ch) temp_done = 1'b1; else rate_done = 1'b1;
    step();
    temp_done = 1'b0;
    rate_done = 1'b0;
  endtask

  task automatic t_reset();
    step();
    chk(rdy_n == 1'b1, "R10 rdy", rdy_n, 1);
    chk(!rate_upd && !temp_upd, "R10 upd", {rate_upd, temp_upd}, 0);
    chk(rate_data == 0 && temp_data == 0, "R10 data", rate_data + temp_data, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_any_mode();
    int oth;
    wait_upd(1'b0, oth);
    chk(rate_data == 0, "R9 first sample", rate_data, 0);
    chk(rdy_n == 1'b0, "R2 low on rate", rdy_n, 0);
    for (int i = 0; i < PER - 1; i++) step();
    chk(!temp_upd && !rate_upd, "R1 gap quiet", temp_upd, 0);
    step();
    chk(temp_upd == 1'b1, "R1 temp after period", temp_upd, 1);
    chk(temp_data == 1, "R9 temp sample", temp_data, 1);
    step();
    chk(temp_upd == 1'b0, "R11 pulse width", temp_upd, 0);
    pulse_done(1'b0);
    chk(rdy_n == 1'b1, "R4 read releases", rdy_n, 1);
  endtask

  task automatic t_all_mode();
    int oth;
    logic [DW-1:0] r;
    all_mode = 1'b1;
    pulse_done(1'b1);
    wait_upd(1'b0, oth);
    r = rate_data;
    chk(rdy_n == 1'b1, "R3 one of two stays high", rdy_n, 1);
    wait_upd(1'b1, oth);
    chk(rdy_n == 1'b0, "R3 both unread low", rdy_n, 0);
    chk(temp_data == r + 1, "R9 consecutive", temp_data, r + 1);
    pulse_done(1'b1);
    chk(rdy_n == 1'b1, "R4 temp read releases", rdy_n, 1);
    pulse_done(1'b0);
  endtask

  task automatic t_disable();
    int oth;
    logic [DW-1:0] y, t;
    temp_en = 1'b0;
    t = temp_data;
    wait_upd(1'b0, oth);
    y = rate_data;
    chk(rdy_n == 1'b0, "R5 R3 only enabled counted", rdy_n, 0);
    wait_upd(1'b0, oth);
    chk(oth == 0, "R5 no temp pulse", oth, 0);
    chk(temp_data == t, "R5 temp data kept", temp_data, t);
    chk(rate_data == y + 2, "R5 slot consumed", rate_data, y + 2);
    pulse_done(1'b0);
    temp_en = 1'b1;
  endtask

  task automatic t_collision();
    int oth;
    logic [DW-1:0] x;
    all_mode = 1'b0;
    wait_upd(1'b0, oth);
    x = rate_data;
    pulse_done(1'b0);
    rate_busy = 1'b1;
    wait_upd(1'b1, oth);
    chk(temp_data == x + 1, "R9 temp between", temp_data, x + 1);
    for (int i = 0; i < PER; i++) step();
    chk(rate_upd == 1'b0, "R6 no pulse while busy", rate_upd, 0);
    chk(rate_data == x, "R6 old word kept", rate_data, x);
    rate_busy = 1'b0;
    pulse_done(1'b1);
    wait_upd(1'b1, oth);
    chk(temp_data == x + 3, "R6 temp continues", temp_data, x + 3);
    wait_upd(1'b0, oth);
    chk(rate_data == x + 4, "R6 R9 sample dropped", rate_data, x + 4);
  endtask

  task automatic t_same_cycle();
    for (int i = 0; i < PER - 1; i++) step();
    rate_done = 1'b1;
    step();
    rate_done = 1'b0;
    chk(temp_upd == 1'b1, "R1 temp slot", temp_upd, 1);
    chk(rdy_n == 1'b0, "R4 update wins over read", rdy_n, 0);
    pulse_done(1'b1);
    chk(rdy_n == 1'b1, "R4 released after", rdy_n, 1);
  endtask

  task automatic t_sync();
    int seen = 0;
    logic [DW-1:0] r, t;
    sync_en = 1'b1;
    sync_p  = 1'b0;
    r = rate_data;
    t = temp_data;
    for (int i = 0; i < 4 * PER; i++) begin
      step();
      if (rate_upd || temp_upd) seen++;
    end
    chk(seen == 0, "R7 frozen", seen, 0);
    chk(rate_data == r && temp_data == t, "R7 data held", rate_data, r);
    sync_p = 1'b1;
    for (int i = 0; i < PER - 1; i++) begin
      step();
      if (rate_upd || temp_upd) seen++;
    end
    chk(seen == 0, "R8 not early", seen, 0);
    step();
    chk(rate_upd == 1'b1, "R8 rate first", rate_upd, 1);
    chk(temp_upd == 1'b0, "R8 not temp", temp_upd, 0);
    sync_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_any_mode();
    t_all_mode();
    t_disable();
    t_collision();
    t_same_cycle();
    t_sync();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule